// File: doc/BRIEF.md
# In-Frame Response Transmit Sequencer

This block sends a multi-byte in-frame response on a single-wire, J1850-style bus once the main part of a received message has ended. The host writes a byte into a one-byte holding register and raises a transmit request. When the response window opens, the sequencer copies the held byte into a shift register and raises a holding-register-empty flag, which is also gated onto an interrupt line. The host refills the holding register for each further byte. When the host gives the end-of-data command, the sequencer closes the response with an end-of-data symbol after the last byte. No CRC byte is ever appended.

The bus is modelled at bit level. A `bit_stb` pulse marks the end of each bit slot. During a slot the block drives `tx_bit`, and the bus echo arrives on `rx_bit`. Frame events from the receiver arrive as single-cycle strobes. If the host fails to refill the holding register in time, or arbitration is lost, the sequencer stops. It leaves behind a sticky flag and cleared request state. In some of these cases it first emits two extra 1-bits so that the byte boundary is broken on purpose.

Top module: `ifr_tx_seq`

## Requirements
- R1: When a held byte moves into the shifter, `tdre` goes high on the next cycle. `irq` equals `tdre` AND `ie`. A host byte write clears `tdre`.
- R2: If the end-of-data command is pending when a byte's last bit slot ends and no byte is held, the next slot carries the end-of-data symbol (`tx_eod`=1, `tx_en`=1). After that slot the transmitter goes idle and `req` clears. No further data bits are sent.
- R3: Bytes go out most-significant bit first, one bit per slot. A held byte is chained directly after the previous byte with no gap slot. Bit value 1 is passive on the bus and 0 is active.
- R4: The response window opens on `ev_eod` and closes on `ev_eof` or `ev_nb`. Transmission starts only while the window is open, `req` is set and a byte is held. A request raised after the window closes stays pending, and the response is sent after the next `ev_eod`.
- R5: A request raised after `ev_nb` in the current message does not start a transmission in that message.
- R6: `ev_ifr_ok` or `ev_rx_err` clears `req`.
- R7: Underrun occurs when no byte is held and no end-of-data command is pending at the end of a byte. The block then sends two further slots of bit 1 and then disables itself. It sets `underrun`, clears `req`, and pulses `inv_sym` for one cycle right after the second extra slot.
- R8: Arbitration is lost when a slot drives passive (1) and the echo reads active (0). If this happens on any bit but the last of a byte, the transmitter is off from the next slot. The block sets `arb_lost`, clears `req` and discards the held byte.
- R9: If arbitration is lost on the last bit of a byte, two further slots of bit 1 are sent before the transmitter turns off. `arb_lost` is set and `underrun` stays clear.
- R10: `underrun` and `arb_lost` stay set until the host pulses `flag_clr` with bit 0 (underrun) or bit 1 (arbitration) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ie | input | 1 | Interrupt enable |
| host_wr | input | 1 | Pulse: write `host_data` to holding register |
| host_data | input | DATA_W | Byte to hold |
| req_set | input | 1 | Pulse: raise transmit request |
| eod_cmd | input | 1 | Pulse: end response after current bytes |
| flag_clr | input | 2 | Write-1-to-clear: bit0 underrun, bit1 arbitration |
| ev_eod | input | 1 | Strobe: end of data of received message |
| ev_eof | input | 1 | Strobe: end of frame |
| ev_nb | input | 1 | Strobe: normalization bit from another responder |
| ev_ifr_ok | input | 1 | Strobe: another node finished a response |
| ev_rx_err | input | 1 | Strobe: receive error |
| bit_stb | input | 1 | End of the current bit slot |
| rx_bit | input | 1 | Echoed bus level for the slot (1 passive) |
| tx_en | output | 1 | Transmitter active |
| tx_bit | output | 1 | Bit driven in the current slot |
| tx_eod | output | 1 | Current slot carries end-of-data symbol |
| tdre | output | 1 | Holding register empty flag |
| irq | output | 1 | Interrupt request |
| req | output | 1 | Transmit request state |
| underrun | output | 1 | Sticky underrun flag |
| arb_lost | output | 1 | Sticky arbitration-loss flag |
| inv_sym | output | 1 | One-cycle invalid-symbol report after underrun padding |

## Verification
The assertions assume that every host write and frame strobe is a single-cycle pulse. They also assume that `bit_stb` pulses stay apart from the frame strobes, and that `ev_eod` never shares a cycle with `ev_nb`. The bench drives each stimulus on a falling edge and holds it for one clock, and it never overlaps two strobes. It echoes `tx_bit` back on `rx_bit` unless a scenario deliberately pulls a slot active. It closes each response window with `ev_eof` before the next scenario starts, so that no open window carries over between tests.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_PAD  = 2'd2,
    ST_EOD  = 2'd3
  } ifr_state_e;
endpackage

// File: rtl/ifr_shifter.sv
module ifr_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  output logic              msb,
  output logic              last
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= load_val;
      cnt_q <= '0;
    end else if (shift) begin
      sh_q  <= {sh_q[DATA_W-2:0], 1'b1};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign msb  = sh_q[DATA_W-1];
  assign last = (cnt_q == CNT_W'(DATA_W-1));

  // R3: a fresh byte always restarts at its first bit
  p_load_restart_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> !last);
endmodule

// File: rtl/ifr_window.sv
module ifr_window (
  input  logic clk,
  input  logic rst,
  input  logic ev_eod,
  input  logic ev_eof,
  input  logic ev_nb,
  input  logic req_set,
  input  logic req_drop,
  input  logic ev_ifr_ok,
  input  logic ev_rx_err,
  output logic win_open,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      win_open <= 1'b0;
      req      <= 1'b0;
    end else begin
      if (ev_eod)              win_open <= 1'b1;
      else if (ev_eof || ev_nb) win_open <= 1'b0;
      if (req_drop || ev_ifr_ok || ev_rx_err) req <= 1'b0;
      else if (req_set)                       req <= 1'b1;
    end
  end

  // R5: a foreign normalization bit shuts the window
  p_nb_closes_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_nb && !ev_eod) |=> !win_open);
  // R6: foreign response or receive error removes the request
  p_req_cleared_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_ifr_ok || ev_rx_err) |=> !req);
endmodule

// File: rtl/ifr_tx_seq.sv
module ifr_tx_seq #(
  parameter int DATA_W   = 8,
  parameter int PAD_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ie,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              req_set,
  input  logic              eod_cmd,
  input  logic [1:0]        flag_clr,
  input  logic              ev_eod,
  input  logic              ev_eof,
  input  logic              ev_nb,
  input  logic              ev_ifr_ok,
  input  logic              ev_rx_err,
  input  logic              bit_stb,
  input  logic              rx_bit,
  output logic              tx_en,
  output logic              tx_bit,
  output logic              tx_eod,
  output logic              tdre,
  output logic              irq,
  output logic              req,
  output logic              underrun,
  output logic              arb_lost,
  output logic              inv_sym
);
  import ifr_pkg::*;

  localparam int PAD_W = $clog2(PAD_BITS + 1);

  ifr_state_e        state_q, state_n;
  logic [DATA_W-1:0] hold_q;
  logic              hold_full_q, eod_pend_q, pad_ur_q;
  logic [PAD_W-1:0]  pad_cnt_q;

  logic win_open, sh_msb, sh_last;
  logic sh_load, sh_shift, req_drop, ur_evt, arb_evt, pad_done, lose;

  ifr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .load_val(hold_q),
    .shift(sh_shift), .msb(sh_msb), .last(sh_last)
  );

  ifr_window u_win (
    .clk(clk), .rst(rst), .ev_eod(ev_eod), .ev_eof(ev_eof), .ev_nb(ev_nb),
    .req_set(req_set), .req_drop(req_drop), .ev_ifr_ok(ev_ifr_ok),
    .ev_rx_err(ev_rx_err), .win_open(win_open), .req(req)
  );

  assign lose = sh_msb && !rx_bit;

  always_comb begin
    state_n  = state_q;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    req_drop = 1'b0;
    ur_evt   = 1'b0;
    arb_evt  = 1'b0;
    pad_done = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (win_open && req && hold_full_q) begin
          sh_load = 1'b1;
          state_n = ST_DATA;
        end
      end
      ST_DATA: begin
        if (bit_stb) begin
          if (sh_last) begin
            if (lose) begin
              arb_evt = 1'b1; req_drop = 1'b1; state_n = ST_PAD;
            end else if (hold_full_q) begin
              sh_load = 1'b1;
            end else if (eod_pend_q) begin
              state_n = ST_EOD;
            end else begin
              ur_evt = 1'b1; req_drop = 1'b1; state_n = ST_PAD;
            end
          end else if (lose) begin
            arb_evt = 1'b1; req_drop = 1'b1; state_n = ST_IDLE;
          end else begin
            sh_shift = 1'b1;
          end
        end
      end
      ST_PAD: begin
        if (bit_stb && pad_cnt_q == PAD_W'(PAD_BITS - 1)) begin
          pad_done = 1'b1;
          state_n  = ST_IDLE;
        end
      end
      default: begin
        if (bit_stb) begin
          req_drop = 1'b1;
          state_n  = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      tdre        <= 1'b0;
      eod_pend_q  <= 1'b0;
      pad_cnt_q   <= '0;
      pad_ur_q    <= 1'b0;
      underrun    <= 1'b0;
      arb_lost    <= 1'b0;
      inv_sym     <= 1'b0;
    end else begin
      state_q <= state_n;
      if (sh_load) begin
        hold_full_q <= 1'b0;
        tdre        <= 1'b1;
      end
      if (arb_evt) hold_full_q <= 1'b0;
      if (host_wr) begin
        hold_q      <= host_data;
        hold_full_q <= 1'b1;
        tdre        <= 1'b0;
      end
      if (arb_evt || ur_evt || (state_q == ST_EOD && bit_stb)) eod_pend_q <= 1'b0;
      else if (eod_cmd)                                        eod_pend_q <= 1'b1;
      if (state_n == ST_PAD && state_q != ST_PAD) begin
        pad_cnt_q <= '0;
        pad_ur_q  <= ur_evt;
      end else if (state_q == ST_PAD && bit_stb) begin
        pad_cnt_q <= pad_cnt_q + 1'b1;
      end
      inv_sym <= pad_done && pad_ur_q;
      if (ur_evt)           underrun <= 1'b1;
      else if (flag_clr[0]) underrun <= 1'b0;
      if (arb_evt)          arb_lost <= 1'b1;
      else if (flag_clr[1]) arb_lost <= 1'b0;
    end
  end

  assign tx_en  = (state_q != ST_IDLE);
  assign tx_bit = (state_q == ST_DATA) ? sh_msb : 1'b1;
  assign tx_eod = (state_q == ST_EOD);
  assign irq    = tdre && ie;

  // R2: end-of-data symbol only follows a pending host command
  p_eod_needs_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_eod) |-> $past(eod_pend_q));
  // R4: no transmission begins with the window shut
  p_no_start_closed_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !win_open) |=> !tx_en);
  // R7: transmitter never goes quiet with the request still raised
  p_req_gone_at_stop_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |-> !req);
  // R8: mid-byte arbitration loss stops at the very next slot
  p_arb_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA && bit_stb && tx_bit && !rx_bit && !sh_last) |=> !tx_en);
  // R10: flags only drop on a host clear
  p_ur_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(underrun) |-> $past(flag_clr[0]));
  p_arb_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(arb_lost) |-> $past(flag_clr[1]));
endmodule

// File: tb/sim_ifr_tx_seq.sv
module sim_ifr_tx_seq;
  logic clk = 1'b0, rst = 1'b1, ie = 1'b1;
  logic host_wr = 0, req_set = 0, eod_cmd = 0, bit_stb = 0, rx_bit = 1;
  logic ev_eod = 0, ev_eof = 0, ev_nb = 0, ev_ifr_ok = 0, ev_rx_err = 0;
  logic [7:0] host_data = '0;
  logic [1:0] flag_clr = '0;
  logic tx_en, tx_bit, tx_eod, tdre, irq, req, underrun, arb_lost, inv_sym;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  ifr_tx_seq u0 (
    .clk(clk), .rst(rst), .ie(ie), .host_wr(host_wr), .host_data(host_data),
    .req_set(req_set), .eod_cmd(eod_cmd), .flag_clr(flag_clr), .ev_eod(ev_eod),
    .ev_eof(ev_eof), .ev_nb(ev_nb), .ev_ifr_ok(ev_ifr_ok), .ev_rx_err(ev_rx_err),
    .bit_stb(bit_stb), .rx_bit(rx_bit), .tx_en(tx_en), .tx_bit(tx_bit),
    .tx_eod(tx_eod), .tdre(tdre), .irq(irq), .req(req), .underrun(underrun),
    .arb_lost(arb_lost), .inv_sym(inv_sym)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse(input int sel);
    @(negedge clk);
    case (sel)
      0: req_set = 1; 1: eod_cmd = 1; 2: ev_eod = 1; 3: ev_eof = 1;
      4: ev_nb = 1; 5: ev_ifr_ok = 1; 6: ev_rx_err = 1;
      7: flag_clr = 2'b01; 8: flag_clr = 2'b10; default: ;
    endcase
    @(negedge clk);
    {req_set, eod_cmd, ev_eod, ev_eof, ev_nb, ev_ifr_ok, ev_rx_err} = '0;
    flag_clr = '0;
  endtask

  task automatic write_byte(input logic [7:0] v);
    @(negedge clk); host_wr = 1; host_data = v;
    @(negedge clk); host_wr = 0;
  endtask

  // n slots; slot number pull_at (1-based) echoes active. bits[n-1] is first slot.
  task automatic slots(input int n, input int pull_at, output logic [15:0] bits,
                       output logic [15:0] ens, output logic [15:0] eods);
    bits = '0; ens = '0; eods = '0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      bits = {bits[14:0], tx_bit};
      ens  = {ens[14:0], tx_en};
      eods = {eods[14:0], tx_eod};
      rx_bit = (i == pull_at) ? 1'b0 : tx_bit;
      bit_stb = 1;
      @(negedge clk);
      bit_stb = 0; rx_bit = 1;
    end
  endtask

  task automatic t_reset();
    chk("R1 reset tx_en", tx_en, 0); chk("R1 reset tdre", tdre, 0);
    chk("R6 reset req", req, 0); chk("R10 reset flags", {underrun, arb_lost}, 0);
  endtask

  task automatic t_single();
    logic [15:0] b, e, d;
    write_byte(8'hA5); pulse(0); pulse(2); tick();
    chk("R1 tdre after copy", tdre, 1); chk("R1 irq", irq, 1);
    ie = 0; #1 chk("R1 irq masked", irq, 0); ie = 1;
    pulse(1);
    slots(9, 0, b, e, d);
    chk("R3 msb-first A5", b[8:1], 8'hA5);
    chk("R2 eod slot", {d[0], e[0]}, 2'b11);
    chk("R2 data slots not eod", d[8:1], 0);
    tick(); chk("R2 idle after eod", tx_en, 0); chk("R2 req cleared", req, 0);
    pulse(3);
  endtask

  task automatic t_multi();
    logic [15:0] b, e, d, b2, e2, d2;
    write_byte(8'h3C); pulse(0); pulse(2); tick();
    write_byte(8'h81);
    chk("R1 write clears tdre", tdre, 0);
    pulse(1);
    slots(8, 0, b, e, d);
    chk("R1 tdre on chained copy", tdre, 1);
    slots(9, 0, b2, e2, d2);
    chk("R3 first byte", b[7:0], 8'h3C);
    chk("R3 second byte chained", b2[8:1], 8'h81);
    chk("R3 continuous enable", {e[7:0], e2[8:0]}, 17'h1FFFF);
    chk("R2 eod after last byte only", d2[0], 1);
    pulse(3);
  endtask

  task automatic t_late();
    logic [15:0] b, e, d;
    pulse(2); pulse(3);
    write_byte(8'h5A); pulse(0);
    repeat (4) tick();
    chk("R4 late request no start", tx_en, 0);
    chk("R4 late request pending", req, 1);
    pulse(2); tick();
    chk("R4 starts after next eod", tx_en, 1);
    pulse(1);
    slots(9, 0, b, e, d);
    chk("R4 pending byte sent", b[8:1], 8'h5A);
    pulse(3);
  endtask

  task automatic t_nb();
    pulse(2); pulse(4);
    write_byte(8'h55); pulse(0);
    repeat (4) tick();
    chk("R5 request after nb no start", tx_en, 0);
    pulse(5); chk("R6 foreign ifr clears req", req, 0);
    pulse(0); chk("R6 req re-raised", req, 1);
    pulse(6); chk("R6 rx error clears req", req, 0);
    pulse(3);
  endtask

  task automatic t_underrun();
    logic [15:0] b, e, d;
    write_byte(8'hC3); pulse(0); pulse(2); tick();
    slots(10, 0, b, e, d);
    chk("R7 byte sent", b[9:2], 8'hC3);
    chk("R7 two pad ones", {b[1:0], e[1:0]}, 4'hF);
    chk("R7 invalid symbol pulse", inv_sym, 1);
    tick();
    chk("R7 transmitter off", tx_en, 0); chk("R7 underrun flag", underrun, 1);
    chk("R7 req cleared", req, 0); chk("R7 pulse single", inv_sym, 0);
    pulse(3);
    repeat (3) tick(); chk("R10 underrun sticky", underrun, 1);
    pulse(8); chk("R10 wrong clear bit", underrun, 1);
    pulse(7); chk("R10 underrun cleared", underrun, 0);
  endtask

  task automatic t_arb_mid();
    logic [15:0] b, e, d;
    write_byte(8'hFF); pulse(0); pulse(2); tick();
    write_byte(8'h0F);
    slots(4, 4, b, e, d);
    tick();
    chk("R8 stop after loss", tx_en, 0); chk("R8 arb flag", arb_lost, 1);
    chk("R8 req cleared", req, 0); chk("R8 underrun not set", underrun, 0);
    pulse(0); repeat (4) tick();
    chk("R8 held byte dropped", tx_en, 0);
    pulse(3); pulse(6);
    pulse(7); chk("R10 arb needs own clear", arb_lost, 1);
    pulse(8); chk("R10 arb cleared", arb_lost, 0);
  endtask

  task automatic t_arb_last();
    logic [15:0] b, e, d;
    write_byte(8'hFF); pulse(0); pulse(2); tick();
    slots(10, 8, b, e, d);
    chk("R9 two pad ones after last-bit loss", {b[1:0], e[1:0]}, 4'hF);
    tick();
    chk("R9 off after pad", tx_en, 0); chk("R9 arb flag", arb_lost, 1);
    chk("R9 no underrun", underrun, 0); chk("R9 no invalid symbol", inv_sym, 0);
    pulse(3); pulse(8);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0; tick();
    t_reset(); t_single(); t_multi(); t_late(); t_nb();
    t_underrun(); t_arb_mid(); t_arb_last();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule